// File: doc/BRIEF.md
# Two-Wire Slave Front End for a 12-bit DAC

This block is the serial control port of a single-channel voltage-output DAC. It watches the two open-drain bus lines with a fast system clock, recognises bus framing (START, repeated START, STOP), and decides whether an address byte is meant for it. The 7-bit address is a fixed 4-bit code, two bits fixed at build time, and one bit taken live from an input pin. Two identical converters can therefore share one bus.

When it is addressed for writing, the block takes one command byte. It then takes pairs of data bytes and loads each complete pair into the DAC input register. The command can also copy the value into a nonvolatile shadow register. When it is addressed for reading, it streams out the input register and then the shadow value. The master ends the stream with a NAK. The block only asserts an open-drain pull-down enable. The pad, the analog path and the real nonvolatile cell programming sit outside it.

Top module: `dac_i2c_slave`

## Requirements
- R1: After reset, `dac_code_o` equals `DAC_RST` (zero by default), `nv_code_o` equals `NV_RST` (zero by default), and `sda_oe_o` and `dac_load_o` are low.
- R2: The first byte after a START is the address, sent MSB first as {1100, A2, A1, A0, RW}. When the address matches, the slave pulls SDA low during the ninth clock. RW = 1 selects a read and RW = 0 selects a write.
- R3: A2 and A1 come from the parameter `ADDR_HI_BITS` (default 2'b00). An address that differs in these bits is not acknowledged.
- R4: The received A0 bit must equal the level on `a0_pin_i` when the address byte completes. Otherwise the address is not acknowledged.
- R5: After an address mismatch, SDA stays released, and all further bytes are neither acknowledged nor acted on until the next START or STOP.
- R6: In a write, the byte after the address is the command, and then data arrives as a high byte (code bits 11:4) and a low byte (code bits 3:0 in positions 7:4). Every byte is acknowledged. When command bits 7:6 = 00, the code is loaded into `dac_code_o`, and `dac_load_o` pulses for one cycle as the ACK of the low byte is driven.
- R7: When command bits 7:6 = 01, the code is loaded into both `dac_code_o` and `nv_code_o`. The shadow value never changes except with a load pulse.
- R8: When command bits 7:6 = 1x, the data bytes are acknowledged but neither register changes and no load pulse occurs.
- R9: After the command, further data byte pairs each perform one more load using the same command.
- R10: A read returns four bytes in a repeating order: DAC high, DAC low, shadow high, shadow low, then DAC high again. Each byte is packed as in R6.
- R11: After the master NAKs a read byte, the slave releases SDA at once and drives nothing until the next START or STOP.
- R12: A START or STOP that arrives part-way through a byte abandons the transfer without any register change. A repeated START begins a new address phase.
- R13: The slave changes its SDA drive only while SCL is low, and keeps it steady through every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| a0_pin_i | input | 1 | Level that sets the lowest address bit |
| sda_oe_o | output | 1 | High to pull SDA low (open-drain enable) |
| dac_code_o | output | DAC_BITS | DAC input register |
| nv_code_o | output | DAC_BITS | Nonvolatile shadow value |
| dac_load_o | output | 1 | One-cycle pulse when the DAC input register is loaded |

## Verification
Two actions can land on the same system clock edge. The first is the register load at the end of a data pair. The second is the start of the slave's ACK drive. Both are triggered by the SCL fall that ends the low byte. The bench counts load pulses on every write and then checks the acknowledge bit and the register value. A checker ties each pulse to an ACK drive that has just begun. A bus abort can also coincide with an in-progress byte. The bench provokes this with a START and a STOP injected after a partial low byte, and judges it by reading the register back unchanged, both over the bus and at the port.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   // protocol engine state
   typedef enum logic [2:0] {
      ST_IDLE,   // bus free or not yet framed
      ST_RECV,   // shifting a byte in from the master
      ST_ACK,    // pulling SDA low for the acknowledge clock
      ST_SEND,   // shifting a byte out to the master
      ST_MACK,   // listening for the master acknowledge
      ST_SKIP    // not addressed, waiting for framing
   } link_st_e;

   // meaning of the byte being received
   typedef enum logic [1:0] {
      PH_ADDR,
      PH_CMD,
      PH_DHI,
      PH_DLO
   } rx_phase_e;

   // fixed upper nibble of the device address
   localparam logic [3:0] DEV_CODE = 4'b1100;

   // command target field values (command bits 7:6)
   localparam logic [1:0] TGT_VOL  = 2'b00;
   localparam logic [1:0] TGT_BOTH = 2'b01;

endpackage

// File: rtl/dacif_line_cond.sv
module dacif_line_cond #(
   parameter int SYNC_STAGES = 2,
   parameter bit DEGLITCH    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dacif_line_cond: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
   logic scl_raw, sda_raw;
   logic scl_f, sda_f;
   logic scl_p, sda_p;

   // metastability chains, idle bus level is high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sy <= '1;
         sda_sy <= '1;
      end else begin
         scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
         sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      end
   end

   assign scl_raw = scl_sy[SYNC_STAGES-1];
   assign sda_raw = sda_sy[SYNC_STAGES-1];

   generate
      if (DEGLITCH) begin : g_deglitch
         // a new level is accepted only after two equal samples
         logic scl_q, sda_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q <= 1'b1;
               sda_q <= 1'b1;
               scl_f <= 1'b1;
               sda_f <= 1'b1;
            end else begin
               scl_q <= scl_raw;
               sda_q <= sda_raw;
               if (scl_raw == scl_q) scl_f <= scl_raw;
               if (sda_raw == sda_q) sda_f <= sda_raw;
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_f <= 1'b1;
               sda_f <= 1'b1;
            end else begin
               scl_f <= scl_raw;
               sda_f <= sda_raw;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_f;
         sda_p <= sda_f;
      end
   end

   assign scl_lvl   = scl_f;
   assign sda_lvl   = sda_f;
   assign scl_rise  = scl_f & ~scl_p;
   assign scl_fall  = ~scl_f & scl_p;
   assign start_det = scl_f & scl_p & sda_p & ~sda_f;
   assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;

endmodule

// File: rtl/dacif_addr_match.sv
module dacif_addr_match
   import dacif_pkg::*;
#(
   parameter logic [1:0] ADDR_HI_BITS = 2'b00
) (
   input  logic [7:0] addr_byte,
   input  logic       a0_pin,
   output logic       hit,
   output logic       rd
);

   logic code_ok, hi_ok, a0_ok;

   assign code_ok = (addr_byte[7:4] == DEV_CODE);
   assign hi_ok   = (addr_byte[3:2] == ADDR_HI_BITS);
   assign a0_ok   = (addr_byte[1] == a0_pin);
   assign hit     = code_ok & hi_ok & a0_ok;
   assign rd      = addr_byte[0];

endmodule

// File: rtl/dacif_rd_mux.sv
module dacif_rd_mux #(
   parameter int DAC_BITS = 12
) (
   input  logic [1:0]          idx,
   input  logic [DAC_BITS-1:0] vol_code,
   input  logic [DAC_BITS-1:0] nv_code,
   output logic [7:0]          byte_o
);

   localparam int PAD = 16 - DAC_BITS;

   logic [15:0] vol_w, nv_w;

   // left-justify each code in a 16-bit word, zero filled below
   assign vol_w = 16'(vol_code) << PAD;
   assign nv_w  = 16'(nv_code) << PAD;

   always_comb begin
      unique case (idx)
         2'd0:    byte_o = vol_w[15:8];
         2'd1:    byte_o = vol_w[7:0];
         2'd2:    byte_o = nv_w[15:8];
         default: byte_o = nv_w[7:0];
      endcase
   end

endmodule

// File: rtl/dac_i2c_slave.sv
module dac_i2c_slave
   import dacif_pkg::*;
#(
   parameter int                  DAC_BITS     = 12,
   parameter int                  SYNC_STAGES  = 2,
   parameter bit                  DEGLITCH     = 1'b1,
   parameter logic [1:0]          ADDR_HI_BITS = 2'b00,
   parameter logic [DAC_BITS-1:0] DAC_RST      = '0,
   parameter logic [DAC_BITS-1:0] NV_RST       = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_i,
   input  logic                sda_i,
   input  logic                a0_pin_i,
   output logic                sda_oe_o,
   output logic [DAC_BITS-1:0] dac_code_o,
   output logic [DAC_BITS-1:0] nv_code_o,
   output logic                dac_load_o
);

   localparam int PAD = 16 - DAC_BITS;

   generate
      if (DAC_BITS < 9 || DAC_BITS > 16) begin : g_bad_width
         $error("dac_i2c_slave: DAC_BITS must lie in 9..16 to fit two bytes");
      end
   endgenerate

   // bus conditioning
   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

   dacif_line_cond #(
      .SYNC_STAGES (SYNC_STAGES),
      .DEGLITCH    (DEGLITCH)
   ) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   // protocol state
   link_st_e            state_q;
   rx_phase_e           phase_q;
   logic [3:0]          bit_cnt_q;
   logic [7:0]          rx_sh_q;
   logic [7:0]          tx_sh_q;
   logic [7:0]          hi_q;
   logic [1:0]          tgt_q;
   logic [1:0]          rd_idx_q;
   logic                rw_q;
   logic                mack_q;
   logic                sda_oe_q;
   logic                dac_load_q;
   logic [DAC_BITS-1:0] dac_q, nv_q;

   // address decode on the shifted byte
   logic adr_hit, adr_rd;

   dacif_addr_match #(
      .ADDR_HI_BITS (ADDR_HI_BITS)
   ) u_match (
      .addr_byte (rx_sh_q),
      .a0_pin    (a0_pin_i),
      .hit       (adr_hit),
      .rd        (adr_rd)
   );

   // byte to transmit for the current read index
   logic [7:0] tx_byte;

   dacif_rd_mux #(
      .DAC_BITS (DAC_BITS)
   ) u_rdmux (
      .idx      (rd_idx_q),
      .vol_code (dac_q),
      .nv_code  (nv_q),
      .byte_o   (tx_byte)
   );

   logic                upd_vol, upd_nv;
   logic [DAC_BITS-1:0] rx_code;
   rx_phase_e           phase_nx;

   assign upd_vol = (tgt_q == TGT_VOL) || (tgt_q == TGT_BOTH);
   assign upd_nv  = (tgt_q == TGT_BOTH);
   assign rx_code = DAC_BITS'({hi_q, rx_sh_q} >> PAD);

   always_comb begin
      unique case (phase_q)
         PH_ADDR: phase_nx = PH_CMD;
         PH_CMD:  phase_nx = PH_DHI;
         PH_DHI:  phase_nx = PH_DLO;
         default: phase_nx = PH_DHI;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         phase_q    <= PH_ADDR;
         bit_cnt_q  <= '0;
         rx_sh_q    <= '0;
         tx_sh_q    <= '0;
         hi_q       <= '0;
         tgt_q      <= '0;
         rd_idx_q   <= '0;
         rw_q       <= 1'b0;
         mack_q     <= 1'b0;
         sda_oe_q   <= 1'b0;
         dac_load_q <= 1'b0;
         dac_q      <= DAC_RST;
         nv_q       <= NV_RST;
      end else begin
         dac_load_q <= 1'b0;
         if (start_det) begin
            // START or repeated START: fresh address phase
            state_q   <= ST_RECV;
            phase_q   <= PH_ADDR;
            bit_cnt_q <= '0;
            sda_oe_q  <= 1'b0;
         end else if (stop_det) begin
            state_q  <= ST_IDLE;
            sda_oe_q <= 1'b0;
         end else begin
            unique case (state_q)
               ST_RECV: begin
                  if (scl_rise && bit_cnt_q != 4'd8) begin
                     rx_sh_q   <= {rx_sh_q[6:0], sda_lvl};
                     bit_cnt_q <= bit_cnt_q + 4'd1;
                  end else if (scl_fall && bit_cnt_q == 4'd8) begin
                     unique case (phase_q)
                        PH_ADDR: begin
                           if (adr_hit) begin
                              rw_q     <= adr_rd;
                              rd_idx_q <= '0;
                              sda_oe_q <= 1'b1;
                              state_q  <= ST_ACK;
                           end else begin
                              state_q  <= ST_SKIP;
                           end
                        end
                        PH_CMD: begin
                           tgt_q    <= rx_sh_q[7:6];
                           sda_oe_q <= 1'b1;
                           state_q  <= ST_ACK;
                        end
                        PH_DHI: begin
                           hi_q     <= rx_sh_q;
                           sda_oe_q <= 1'b1;
                           state_q  <= ST_ACK;
                        end
                        default: begin
                           // low byte complete: commit together with ACK
                           sda_oe_q <= 1'b1;
                           state_q  <= ST_ACK;
                           if (upd_vol) begin
                              dac_q      <= rx_code;
                              dac_load_q <= 1'b1;
                           end
                           if (upd_nv) nv_q <= rx_code;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_cnt_q <= '0;
                     if (phase_q == PH_ADDR && rw_q) begin
                        tx_sh_q  <= tx_byte;
                        sda_oe_q <= ~tx_byte[7];
                        state_q  <= ST_SEND;
                     end else begin
                        sda_oe_q <= 1'b0;
                        phase_q  <= phase_nx;
                        state_q  <= ST_RECV;
                     end
                  end
               end
               ST_SEND: begin
                  if (scl_fall) begin
                     if (bit_cnt_q == 4'd7) begin
                        sda_oe_q <= 1'b0;
                        mack_q   <= 1'b0;
                        state_q  <= ST_MACK;
                     end else begin
                        tx_sh_q   <= {tx_sh_q[6:0], 1'b0};
                        sda_oe_q  <= ~tx_sh_q[6];
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     if (sda_lvl) begin
                        state_q <= ST_SKIP;
                     end else begin
                        mack_q   <= 1'b1;
                        rd_idx_q <= rd_idx_q + 2'd1;
                     end
                  end else if (scl_fall && mack_q) begin
                     tx_sh_q   <= tx_byte;
                     sda_oe_q  <= ~tx_byte[7];
                     bit_cnt_q <= '0;
                     state_q   <= ST_SEND;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o   = sda_oe_q;
   assign dac_code_o = dac_q;
   assign nv_code_o  = nv_q;
   assign dac_load_o = dac_load_q;

   // R13: drive only changes while SCL is low
   p_oe_hold_scl_high_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe_q));

   // R12: any START releases the line on the next cycle
   p_start_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe_q);

   // R6: a load coincides with the start of an ACK drive
   p_load_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dac_load_q |-> (sda_oe_q && state_q == ST_ACK && !$past(sda_oe_q)));

   // R7: the shadow value only moves together with a load
   p_nv_with_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(nv_q) |-> dac_load_q);

   // R5: an unaddressed slave keeps the line released
   p_skip_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP) |-> !sda_oe_q);

   // R11: master NAK leaves the line released
   p_nack_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_MACK && scl_rise && sda_lvl) |=> !sda_oe_q);

endmodule

// File: tb/dac_i2c_slave_tb_top.sv
module dac_i2c_slave_tb_top;

   localparam int Q = 8;  // quarter SCL period in system clocks

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic a0_pin = 1'b0;
   logic sda_oe;
   logic [11:0] dac_code, nv_code;
   logic dac_load;
   logic sda_bus;

   assign sda_bus = sda_m & ~sda_oe;

   dac_i2c_slave dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_bus),
      .a0_pin_i   (a0_pin),
      .sda_oe_o   (sda_oe),
      .dac_code_o (dac_code),
      .nv_code_o  (nv_code),
      .dac_load_o (dac_load)
   );

   int n_chk = 0;
   int n_bad = 0;
   int n_load = 0;
   bit done = 1'b0;

   always @(negedge clk) if (rst_n && dac_load) n_load++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; hold(Q);
      sda_m = 1'b0; hold(Q);
      scl_m = 1'b0; hold(Q);
   endtask

   task automatic bus_restart();
      sda_m = 1'b1; hold(Q);
      scl_m = 1'b1; hold(Q);
      sda_m = 1'b0; hold(Q);
      scl_m = 1'b0; hold(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hold(Q);
      scl_m = 1'b1; hold(Q);
      sda_m = 1'b1; hold(Q);
   endtask

   task automatic write_bit(input logic b);
      sda_m = b; hold(Q);
      scl_m = 1'b1; hold(2 * Q);
      scl_m = 1'b0; hold(Q);
   endtask

   task automatic read_bit(output logic b);
      logic s1, s2;
      sda_m = 1'b1; hold(Q);
      scl_m = 1'b1; hold(2);
      s1 = sda_bus;
      hold(2 * Q - 3);
      s2 = sda_bus;
      chk("R13 SDA steady while SCL high", 32'(s2), 32'(s1));
      hold(1);
      scl_m = 1'b0; hold(Q);
      b = s1;
   endtask

   task automatic wr_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) write_bit(v[i]);
      read_bit(b);
      ack = ~b;
   endtask

   task automatic rd_byte(input logic last, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         read_bit(b);
         v[i] = b;
      end
      write_bit(last);
   endtask

   // R1
   task automatic t_reset();
      chk("R1 dac reset", 32'(dac_code), 32'h0);
      chk("R1 nv reset", 32'(nv_code), 32'h0);
      chk("R1 oe reset", 32'(sda_oe), 32'h0);
      chk("R1 load reset", 32'(dac_load), 32'h0);
   endtask

   // R2, R6: volatile-only write
   task automatic t_write_vol();
      logic ack; int l0;
      l0 = n_load;
      bus_start();
      wr_byte(8'hC0, ack); chk("R2 address ACK", 32'(ack), 32'h1);
      wr_byte(8'h00, ack); chk("R6 command ACK", 32'(ack), 32'h1);
      wr_byte(8'hAB, ack); chk("R6 high byte ACK", 32'(ack), 32'h1);
      wr_byte(8'hC0, ack); chk("R6 low byte ACK", 32'(ack), 32'h1);
      bus_stop();
      chk("R6 dac value", 32'(dac_code), 32'hABC);
      chk("R6 nv untouched", 32'(nv_code), 32'h0);
      chk("R6 one load pulse", 32'(n_load - l0), 32'h1);
   endtask

   // R7
   task automatic t_write_both();
      logic ack;
      bus_start();
      wr_byte(8'hC0, ack);
      wr_byte(8'h40, ack);
      wr_byte(8'h12, ack);
      wr_byte(8'h30, ack); chk("R7 low byte ACK", 32'(ack), 32'h1);
      bus_stop();
      chk("R7 dac value", 32'(dac_code), 32'h123);
      chk("R7 nv value", 32'(nv_code), 32'h123);
   endtask

   // R8
   task automatic t_write_reserved();
      logic ack; int l0;
      l0 = n_load;
      bus_start();
      wr_byte(8'hC0, ack);
      wr_byte(8'h80, ack); chk("R8 command ACK", 32'(ack), 32'h1);
      wr_byte(8'hFF, ack);
      wr_byte(8'hF0, ack); chk("R8 data ACK", 32'(ack), 32'h1);
      bus_stop();
      chk("R8 dac unchanged", 32'(dac_code), 32'h123);
      chk("R8 nv unchanged", 32'(nv_code), 32'h123);
      chk("R8 no load pulse", 32'(n_load - l0), 32'h0);
   endtask

   // R9
   task automatic t_stream();
      logic ack; int l0;
      l0 = n_load;
      bus_start();
      wr_byte(8'hC0, ack);
      wr_byte(8'h00, ack);
      wr_byte(8'h45, ack);
      wr_byte(8'h60, ack);
      chk("R9 first pair loaded", 32'(dac_code), 32'h456);
      wr_byte(8'h78, ack);
      wr_byte(8'h90, ack); chk("R9 second pair ACK", 32'(ack), 32'h1);
      bus_stop();
      chk("R9 dac value", 32'(dac_code), 32'h789);
      chk("R9 two loads", 32'(n_load - l0), 32'h2);
      chk("R9 nv unchanged", 32'(nv_code), 32'h123);
   endtask

   // R10, R11
   task automatic t_read();
      logic ack; logic [7:0] v;
      bus_start();
      wr_byte(8'hC1, ack); chk("R10 read address ACK", 32'(ack), 32'h1);
      rd_byte(1'b0, v); chk("R10 byte0 dac hi", 32'(v), 32'h78);
      rd_byte(1'b0, v); chk("R10 byte1 dac lo", 32'(v), 32'h90);
      rd_byte(1'b0, v); chk("R10 byte2 nv hi", 32'(v), 32'h12);
      rd_byte(1'b0, v); chk("R10 byte3 nv lo", 32'(v), 32'h30);
      rd_byte(1'b1, v); chk("R10 wrap to dac hi", 32'(v), 32'h78);
      rd_byte(1'b1, v); chk("R11 released after NAK", 32'(v), 32'hFF);
      chk("R11 oe low", 32'(sda_oe), 32'h0);
      bus_stop();
   endtask

   // R4
   task automatic t_a0_pin();
      logic ack;
      a0_pin = 1'b1; hold(Q);
      bus_start();
      wr_byte(8'hC0, ack); chk("R4 A0 mismatch NAK", 32'(ack), 32'h0);
      bus_stop();
      bus_start();
      wr_byte(8'hC2, ack); chk("R4 A0 match ACK", 32'(ack), 32'h1);
      wr_byte(8'h00, ack);
      wr_byte(8'h5A, ack);
      wr_byte(8'h50, ack);
      bus_stop();
      chk("R4 write via A0=1", 32'(dac_code), 32'h5A5);
      a0_pin = 1'b0; hold(Q);
   endtask

   // R3, R5
   task automatic t_hi_bits_mismatch();
      logic ack; int l0;
      l0 = n_load;
      bus_start();
      wr_byte(8'hC8, ack); chk("R3 A2 set NAK", 32'(ack), 32'h0);
      wr_byte(8'h00, ack); chk("R5 ignored command NAK", 32'(ack), 32'h0);
      wr_byte(8'h11, ack); chk("R5 ignored data NAK", 32'(ack), 32'h0);
      wr_byte(8'h20, ack); chk("R5 ignored data NAK", 32'(ack), 32'h0);
      bus_stop();
      chk("R5 dac unchanged", 32'(dac_code), 32'h5A5);
      chk("R5 no load", 32'(n_load - l0), 32'h0);
      bus_start();
      wr_byte(8'hC4, ack); chk("R3 A1 set NAK", 32'(ack), 32'h0);
      bus_stop();
   endtask

   // R12
   task automatic t_abort();
      logic ack; logic [7:0] v; int l0;
      l0 = n_load;
      bus_start();
      wr_byte(8'hC0, ack);
      wr_byte(8'h00, ack);
      wr_byte(8'hEE, ack);
      for (int i = 0; i < 4; i++) write_bit(1'b0);
      bus_restart();
      wr_byte(8'hC1, ack); chk("R12 address after restart ACK", 32'(ack), 32'h1);
      rd_byte(1'b1, v); chk("R12 readback after restart", 32'(v), 32'h5A);
      bus_stop();
      chk("R12 dac after restart abort", 32'(dac_code), 32'h5A5);
      bus_start();
      wr_byte(8'hC0, ack);
      wr_byte(8'h00, ack);
      wr_byte(8'h11, ack);
      for (int i = 0; i < 3; i++) write_bit(1'b1);
      bus_stop();
      chk("R12 dac after stop abort", 32'(dac_code), 32'h5A5);
      chk("R12 no load on abort", 32'(n_load - l0), 32'h0);
   endtask

   initial begin
      hold(5);
      t_reset();
      rst_n = 1'b1;
      hold(10);
      t_write_vol();
      t_write_both();
      t_write_reserved();
      t_stream();
      t_read();
      t_a0_pin();
      t_hi_bits_mismatch();
      t_abort();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule